// File: doc/BRIEF.md
# High-Speed Entry Detector for a Serial Camera Data Lane

This block sits behind the analog receiver of one data lane and handles the lane's move from low-power signalling into high-speed bursts. It runs on the lane's byte clock. It watches a stop-state flag and a byte stream. When the stop flag drops, a burst begins. One cycle counter then times two things from that point. The first is when the line termination is switched on. The second is when the received bytes become trustworthy.

Once the settle window has passed, the block hunts for a programmable leader byte. The usual value is 0xB8. It locks on the first match, drops that leader byte, and hands every later byte downstream with a valid flag on each byte clock.

Software sets the two delay counts from fixed time budgets. The termination delay is the floor of 20 ns divided by the byte clock period. The settle delay is the floor of 105 ns divided by the byte clock period, plus four. A burst that ends without a leader ever being found is flagged by a single-cycle error pulse.

Top module: `hs_entry_detector`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with the lane in stop state, `term_en_o`, `byte_valid_o` and `sync_err_o` are all low.
- R2: Call the first rising edge that samples `lp_stop_i` low edge k=0 of the burst. `term_en_o` is high after edge k exactly when k >= `term_cnt_i`. A count of 0 switches termination on right after edge 0.
- R3: `term_en_o` stays high for the rest of the burst. It goes low after the first edge that samples `lp_stop_i` high.
- R4: A byte sampled at edge k with k < `settle_cnt_i` is never taken as the leader, even when it equals `sync_pat_i`. `byte_valid_o` stays low for it.
- R5: The first byte sampled at an edge k >= `settle_cnt_i` that equals `sync_pat_i` locks the lane. That leader byte is not delivered. Each byte sampled at a later edge of the burst appears on `byte_o` after that edge, with `byte_valid_o` high on every such cycle.
- R6: The leader value is taken from `sync_pat_i` (0xB8 in normal use). A byte that equals 0xB8 does not lock the lane when `sync_pat_i` holds another value.
- R7: At the first edge that samples `lp_stop_i` high, `byte_valid_o` goes low. If the burst never locked, `sync_err_o` is high for exactly that one cycle. After a locked burst it stays low.
- R8: A settle count of 0 lets the byte sampled at edge 0 act as the leader.
- R9: The burst cycle counter saturates rather than wrapping, so the largest count, 255, still delays termination by 255 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lp_stop_i | input | 1 | High while the lane rests in the low-power stop state |
| byte_i | input | BYTE_W | Deserialized lane byte, one per clock |
| term_cnt_i | input | CNT_W | Edges from burst start to termination enable |
| settle_cnt_i | input | CNT_W | Edges from burst start before leader hunting |
| sync_pat_i | input | BYTE_W | Leader byte to hunt for |
| term_en_o | output | 1 | Line termination enable |
| byte_o | output | BYTE_W | Aligned byte after the leader |
| byte_valid_o | output | 1 | `byte_o` carries a lane byte this cycle |
| sync_err_o | output | 1 | One-cycle pulse: burst ended with no leader found |

## Verification
A wrong burst counter shows up as a termination edge that comes early or late against the programmed count. It also shows as a leader taken too soon or missed. Both are visible within one clock of the edge where the counter is off. A hunter stuck in the wrong phase shows one of three ways: `byte_valid_o` rising before the leader, a valid gap inside a locked burst, or a missing or spurious `sync_err_o` on the single cycle after the stop state returns. Every burst in the bench is checked edge by edge against a model that is built only from the programmed counts and the byte sequence.

// File: rtl/hs_entry_pkg.sv
package hs_entry_pkg;

    // Phase of the leader hunt within one high-speed burst
    typedef enum logic [1:0] {
        HP_IDLE = 2'd0,   // lane in stop state, no burst running
        HP_HUNT = 2'd1,   // burst running, leader not yet seen
        HP_LOCK = 2'd2    // leader seen, bytes are being delivered
    } hunt_phase_e;

endpackage

// File: rtl/hs_burst_timer.sv
module hs_burst_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lp_stop_i,
    input  logic [CNT_W-1:0] term_cnt_i,
    input  logic [CNT_W-1:0] settle_cnt_i,
    output logic             term_en_o,
    output logic             window_open_o
);
    localparam int          TMR_W   = CNT_W + 1;
    localparam logic [TMR_W-1:0] TMR_MAX = '1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             term_en;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (lp_stop_i) begin
            tmr_d.cnt     = '0;
            tmr_d.term_en = 1'b0;
        end else begin
            if (tmr_q.cnt != TMR_MAX) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
            tmr_d.term_en = (tmr_q.cnt >= {1'b0, term_cnt_i});
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign term_en_o     = tmr_q.term_en;
    assign window_open_o = !lp_stop_i && (tmr_q.cnt >= {1'b0, settle_cnt_i});

    AST_TERM_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lp_stop_i |=> !term_en_o);  // R3
    AST_TERM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (term_en_o && !lp_stop_i) |=> term_en_o);  // R3
    AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.cnt == TMR_MAX && !lp_stop_i) |=> tmr_q.cnt == TMR_MAX);  // R9

endmodule

// File: rtl/hs_sync_hunter.sv
module hs_sync_hunter
    import hs_entry_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lp_stop_i,
    input  logic              window_open_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] sync_pat_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              sync_err_o
);
    typedef struct packed {
        hunt_phase_e       phase;
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              err;
    } hunt_t;

    hunt_t hunt_d, hunt_q;
    logic  pat_hit;

    assign pat_hit = window_open_i && (byte_i == sync_pat_i);

    always_comb begin
        hunt_d       = hunt_q;
        hunt_d.valid = 1'b0;
        hunt_d.err   = 1'b0;
        if (lp_stop_i) begin
            hunt_d.phase = HP_IDLE;
            hunt_d.err   = (hunt_q.phase == HP_HUNT);
        end else begin
            unique case (hunt_q.phase)
                HP_LOCK: begin
                    hunt_d.valid = 1'b1;
                    hunt_d.data  = byte_i;
                end
                default: begin
                    hunt_d.phase = pat_hit ? HP_LOCK : HP_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hunt_q       <= '0;
            hunt_q.phase <= HP_IDLE;
        end else begin
            hunt_q <= hunt_d;
        end
    end

    assign byte_o       = hunt_q.data;
    assign byte_valid_o = hunt_q.valid;
    assign sync_err_o   = hunt_q.err;

    AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lp_stop_i |=> !byte_valid_o);  // R7
    AST_VALID_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_valid_o && !lp_stop_i) |=> byte_valid_o);  // R5
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_err_o |=> !sync_err_o);  // R7
    AST_ERR_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_err_o |-> $past(lp_stop_i));  // R7
    AST_ERR_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_err_o |-> !byte_valid_o);  // R7

endmodule

// File: rtl/hs_entry_detector.sv
module hs_entry_detector #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lp_stop_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CNT_W-1:0]  term_cnt_i,
    input  logic [CNT_W-1:0]  settle_cnt_i,
    input  logic [BYTE_W-1:0] sync_pat_i,
    output logic              term_en_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              sync_err_o
);
    logic window_open;

    hs_burst_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .lp_stop_i     (lp_stop_i),
        .term_cnt_i    (term_cnt_i),
        .settle_cnt_i  (settle_cnt_i),
        .term_en_o     (term_en_o),
        .window_open_o (window_open)
    );

    hs_sync_hunter #(
        .BYTE_W (BYTE_W)
    ) i_hunter (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .lp_stop_i     (lp_stop_i),
        .window_open_i (window_open),
        .byte_i        (byte_i),
        .sync_pat_i    (sync_pat_i),
        .byte_o        (byte_o),
        .byte_valid_o  (byte_valid_o),
        .sync_err_o    (sync_err_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_stop_i && $past(lp_stop_i)) |=> !(term_en_o || byte_valid_o || sync_err_o));  // R1

endmodule

// File: tb/test_hs_entry_detector.sv
`timescale 1ns/1ps
module test_hs_entry_detector;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       lp_stop;
    logic [7:0] byte_in;
    logic [7:0] term_cnt;
    logic [7:0] settle_cnt;
    logic [7:0] sync_pat;
    logic       term_en;
    logic [7:0] byte_out;
    logic       byte_valid;
    logic       sync_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hs_entry_detector i_hs_entry_detector (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .lp_stop_i    (lp_stop),
        .byte_i       (byte_in),
        .term_cnt_i   (term_cnt),
        .settle_cnt_i (settle_cnt),
        .sync_pat_i   (sync_pat),
        .term_en_o    (term_en),
        .byte_o       (byte_out),
        .byte_valid_o (byte_valid),
        .sync_err_o   (sync_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int k, input int sync_at, input int decoy_at,
                                           input int alt_at, input logic [7:0] alt_val,
                                           input logic [7:0] pat);
        if (k == sync_at || k == decoy_at) return pat;
        if (k == alt_at) return alt_val;
        return 8'(16 + k);
    endfunction

    // One burst: checks every edge against a model built from the counts
    task automatic do_burst(input string tag, input int n, input int s, input logic [7:0] pat,
                            input int sync_at, input int decoy_at, input int alt_at,
                            input logic [7:0] alt_val, input int len);
        int found = -1;
        for (int k = 0; k < len; k++) begin
            if (found < 0 && k >= s && byte_at(k, sync_at, decoy_at, alt_at, alt_val, pat) == pat)
                found = k;
        end
        @(negedge clk);
        term_cnt   = 8'(n);
        settle_cnt = 8'(s);
        sync_pat   = pat;
        lp_stop    = 1'b0;
        for (int k = 0; k < len; k++) begin
            byte_in = byte_at(k, sync_at, decoy_at, alt_at, alt_val, pat);
            @(posedge clk);
            @(negedge clk);
            chk(term_en == (k >= n), {tag, " R2 term_en"}, term_en, (k >= n));
            chk(byte_valid == (found >= 0 && k > found), {tag, " R4 R5 valid"},
                byte_valid, (found >= 0 && k > found));
            if (found >= 0 && k > found)
                chk(byte_out == byte_in, {tag, " R5 byte"}, byte_out, byte_in);
            chk(sync_err == 1'b0, {tag, " R7 no err in burst"}, sync_err, 0);
        end
        lp_stop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(term_en == 1'b0, {tag, " R3 term off"}, term_en, 0);
        chk(byte_valid == 1'b0, {tag, " R7 valid off"}, byte_valid, 0);
        chk(sync_err == (found < 0), {tag, " R7 err pulse"}, sync_err, (found < 0));
        @(posedge clk);
        @(negedge clk);
        chk(sync_err == 1'b0, {tag, " R7 err one cycle"}, sync_err, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; lp_stop = 1'b1; byte_in = 8'h00;
        term_cnt = 8'd0; settle_cnt = 8'd0; sync_pat = 8'hB8;
        repeat (3) @(negedge clk);
        chk(!term_en && !byte_valid && !sync_err, "R1 in reset", {term_en, byte_valid, sync_err}, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!term_en && !byte_valid && !sync_err, "R1 after release", {term_en, byte_valid, sync_err}, 0);
    endtask

    task automatic t_term_sweep();
        do_burst("term0",  0, 200, 8'hB8, -1, -1, -1, 8'h00, 6);   // R2 immediate
        do_burst("term3",  3, 200, 8'hB8, -1, -1, -1, 8'h00, 8);   // R2
        do_burst("term7",  7, 200, 8'hB8, -1, -1, -1, 8'h00, 12);  // R2 R3
    endtask

    task automatic t_settle() ;
        do_burst("settle0", 2, 0, 8'hB8, 0, -1, -1, 8'h00, 10);    // R8 leader at edge 0
        do_burst("decoy",   2, 10, 8'hB8, 14, 4, -1, 8'h00, 24);   // R4 early leader ignored
        do_burst("edge",    1, 6, 8'hB8, 6, 5, -1, 8'h00, 12);     // R4 R5 boundary k == settle
    endtask

    task automatic t_pattern();
        do_burst("pat47", 2, 3, 8'h47, 12, -1, 8, 8'hB8, 20);      // R6 0xB8 ignored for 0x47
        do_burst("nopat", 2, 3, 8'h47, -1, -1, 5, 8'hB8, 10);      // R6 R7 no lock, error
    endtask

    task automatic t_saturate();
        do_burst("term255", 255, 0, 8'hB8, 3, -1, -1, 8'h00, 262); // R9
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_term_sweep();
        t_settle();
        t_pattern();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule